// File: doc/BRIEF.md
# Repeater Port Connect/Isolate Controller

This block holds a per-port connect/isolate mask for a 14-port Ethernet repeater. The ports are twelve twisted-pair ports, one AUI port and one remote AUI port. From the mask it produces a registered per-port enable that gates repeating to and from each port.

The host writes the mask one byte at a time and can read it back. A per-port receive-activity flag and a global repeating flag decide when a mask change reaches the enable. An isolate always takes effect at once. A connect is held back while a packet is still arriving on that port, and takes effect once that packet has ended.

On reset, every mask bit is loaded from a single external strap input.

Top module: `port_iso_ctrl`

## Requirements
- R1: A mask bit of 0 isolates its port and 1 connects it. The enable of a port is never high while that port's mask bit is 0.
- R2: A write that clears a mask bit drives that port's enable low on the clock edge that samples the write. This holds even while a packet is arriving on the port and while the repeater is repeating.
- R3: A write that sets a mask bit while that port's receive-activity flag is high leaves the enable low. The enable rises on the first clock edge that samples the flag low.
- R4: A write that sets a mask bit while the repeating flag is high and the port's receive-activity flag is low raises the enable on the edge that samples the write.
- R5: A write that sets a mask bit on an idle port, with the repeating flag low, raises the enable on the edge that samples the write.
- R6: A write that clears a mask bit cancels any pending connect on that port. The enable then stays low after the receive-activity flag falls.
- R7: During reset, every mask bit and every enable takes the value of strap_i.
- R8: Byte select 0 maps data bits 7..0 to ports 7..0. Byte select 1 maps data bits 3..0 to ports 11..8, bit 4 to the AUI port (index 12) and bit 5 to the remote AUI port (index 13). Bits 7..6 of byte 1 are ignored on write and read as 0.
- R9: A read returns the stored mask, not the effective enable.
- R10: A write to one byte leaves the mask bits and enables of the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Reset value for every mask bit |
| wr_en_i | input | 1 | Mask byte write strobe |
| wr_byte_i | input | 1 | Byte select for the write |
| wr_data_i | input | 8 | Write data |
| rd_byte_i | input | 1 | Byte select for the read |
| rd_data_o | output | 8 | Read data (stored mask) |
| rx_act_i | input | 14 | Per-port packet-arriving flag |
| repeating_i | input | 1 | Repeater is forwarding a packet |
| port_en_o | output | 14 | Registered effective per-port enable |

## Verification
The bench toggles mask bits on a port while a packet is arriving on it. A design that deferred isolation would keep forwarding a port that should already be cut off. A design that connected immediately would join a packet partway through.

The bench also re-isolates a port whose connect is still pending, then lets the packet end. A design without cancellation would wrongly enable that port.

Writes to the upper byte with the reserved bits set check the AUI and remote AUI positions. A mis-mapped or unmasked byte would show up in the read-back and on the enable.

Each pending case also reads the mask back while the enable is still low. This exposes a read path wired to the enable instead of the stored mask.

// File: rtl/rpt_gate_pkg.sv
package rpt_gate_pkg;
  localparam int unsigned NUM_TP    = 12;
  localparam int unsigned NUM_PORTS = NUM_TP + 2;
  localparam int unsigned AUI_IDX   = NUM_TP;
  localparam int unsigned RAUI_IDX  = NUM_TP + 1;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HI_W      = NUM_PORTS - BYTE_W;
endpackage

// File: rtl/port_mask_regs.sv
module port_mask_regs
  import rpt_gate_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_i,
  input  logic                 wr_en_i,
  input  logic                 wr_byte_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  input  logic                 rd_byte_i,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic [NUM_PORTS-1:0] mask_next_o,
  output logic [BYTE_W-1:0]    rd_data_o
);
  logic [NUM_PORTS-1:0] mask_q;

  always_comb begin
    mask_next_o = mask_q;
    if (wr_en_i) begin
      if (!wr_byte_i) mask_next_o[BYTE_W-1:0]         = wr_data_i;
      else            mask_next_o[NUM_PORTS-1:BYTE_W] = wr_data_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= {NUM_PORTS{strap_i}};
    else         mask_q <= mask_next_o;
  end

  assign mask_o    = mask_q;
  // upper byte: reserved bits read as zero
  assign rd_data_o = rd_byte_i ? {{(BYTE_W-HI_W){1'b0}}, mask_q[NUM_PORTS-1:BYTE_W]}
                               : mask_q[BYTE_W-1:0];

  AST_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_byte_i) |=> (mask_q[NUM_PORTS-1:BYTE_W] == $past(wr_data_i[HI_W-1:0]))); // R8
  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_byte_i) |=> $stable(mask_q[NUM_PORTS-1:BYTE_W])); // R10
endmodule

// File: rtl/port_gate_cell.sv
module port_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_val_i,
  input  logic mask_i,
  input  logic rx_act_i,
  input  logic repeating_i,
  output logic en_o
);
  logic en_q;

  // isolate at once; connect only when no packet is arriving on this port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= rst_val_i;
    else         en_q <= mask_i & (en_q | ~rx_act_i);
  end

  assign en_o = en_q;

  AST_ISO_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_i |=> !en_q); // R2
  AST_HOLD_IN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && rx_act_i) |=> !en_q); // R3
  AST_REPEAT_CONN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repeating_i && mask_i && !rx_act_i) |=> en_q); // R4
  AST_IDLE_CONN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!repeating_i && mask_i && !rx_act_i) |=> en_q); // R5
endmodule

// File: rtl/port_iso_ctrl.sv
module port_iso_ctrl
  import rpt_gate_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_i,
  input  logic                 wr_en_i,
  input  logic                 wr_byte_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 rd_byte_i,
  output logic [7:0]           rd_data_o,
  input  logic [13:0]          rx_act_i,
  input  logic                 repeating_i,
  output logic [13:0]          port_en_o
);
  logic [NUM_PORTS-1:0] mask_q;
  logic [NUM_PORTS-1:0] mask_next;

  port_mask_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_i     (strap_i),
    .wr_en_i     (wr_en_i),
    .wr_byte_i   (wr_byte_i),
    .wr_data_i   (wr_data_i),
    .rd_byte_i   (rd_byte_i),
    .mask_o      (mask_q),
    .mask_next_o (mask_next),
    .rd_data_o   (rd_data_o)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_gate_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rst_val_i   (strap_i),
      .mask_i      (mask_next[p]),
      .rx_act_i    (rx_act_i[p]),
      .repeating_i (repeating_i),
      .en_o        (port_en_o[p])
    );
  end

  AST_EN_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_en_o & ~mask_q) == '0); // R1
endmodule

// File: tb/sim_port_iso_ctrl.sv
`timescale 1ns/1ps
module sim_port_iso_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_byte = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_byte = 1'b0;
  logic [7:0]  rd_data;
  logic [13:0] rx_act = '0;
  logic        repeating = 1'b0;
  logic [13:0] port_en;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  port_iso_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .wr_en_i(wr_en),
    .wr_byte_i(wr_byte), .wr_data_i(wr_data), .rd_byte_i(rd_byte),
    .rd_data_o(rd_data), .rx_act_i(rx_act), .repeating_i(repeating),
    .port_en_o(port_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = b; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic b, output logic [7:0] d);
    rd_byte = b; #1; d = rd_data;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset(1'b0);
    chk("R7 en strap0", port_en, 14'h0000);
    rd(1'b0, d); chk("R7 byte0 strap0", d, 8'h00);
    do_reset(1'b1);
    chk("R7 en strap1", port_en, 14'h3FFF);
    rd(1'b0, d); chk("R7 byte0 strap1", d, 8'hFF);
    rd(1'b1, d); chk("R7 byte1 strap1", d, 8'h3F);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(1'b1, 8'hE5);
    rd(1'b1, d); chk("R8 byte1 readback", d, 8'h25);
    chk("R8 upper enables", port_en[13:8], 6'b100101);
    chk("R8 AUI idx12 off", port_en[12], 1'b0);
    chk("R10 lower untouched", port_en[7:0], 8'hFF);
    rd(1'b0, d); chk("R10 byte0 kept", d, 8'hFF);
    wr(1'b0, 8'h7E);
    chk("R8 byte0 map", port_en[7:0], 8'h7E);
    chk("R10 upper untouched", port_en[13:8], 6'b100101);
    wr(1'b1, 8'h3F); wr(1'b0, 8'hFF);
    chk("R1 all connected", port_en, 14'h3FFF);
  endtask

  task automatic t_isolate_defer();
    logic [7:0] d;
    @(negedge clk); rx_act[3] = 1'b1; repeating = 1'b1;
    wr(1'b0, 8'hF7);
    chk("R2 iso mid packet", port_en[3], 1'b0);
    wr(1'b0, 8'hFF);
    chk("R3 connect deferred", port_en[3], 1'b0);
    rd(1'b0, d); chk("R9 read mask not en", d, 8'hFF);
    repeat (3) @(posedge clk);
    #1 chk("R3 still deferred", port_en[3], 1'b0);
    @(negedge clk); rx_act[3] = 1'b0;
    chk("R3 before edge", port_en[3], 1'b0);
    @(posedge clk); #1;
    chk("R3 connect after rx end", port_en[3], 1'b1);
  endtask

  task automatic t_repeat_connect();
    @(negedge clk); repeating = 1'b1;
    wr(1'b0, 8'hDF);
    chk("R2 iso while repeating", port_en[5], 1'b0);
    wr(1'b0, 8'hFF);
    chk("R4 connect while repeating", port_en[5], 1'b1);
  endtask

  task automatic t_idle_connect();
    @(negedge clk); repeating = 1'b0;
    wr(1'b0, 8'hFE);
    chk("R1 iso port0", port_en[0], 1'b0);
    wr(1'b0, 8'hFF);
    chk("R5 idle connect", port_en[0], 1'b1);
    wr(1'b1, 8'h2F);
    chk("R2 AUI iso", port_en[12], 1'b0);
    wr(1'b1, 8'h3F);
    chk("R5 AUI connect", port_en[12], 1'b1);
  endtask

  task automatic t_cancel();
    logic [7:0] d;
    @(negedge clk); rx_act[2] = 1'b1;
    wr(1'b0, 8'hFB);
    wr(1'b0, 8'hFF);
    chk("R3 pending", port_en[2], 1'b0);
    wr(1'b0, 8'hFB);
    @(negedge clk); rx_act[2] = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk("R6 cancel holds", port_en[2], 1'b0);
    rd(1'b0, d); chk("R6 mask cleared", d, 8'hFB);
    wr(1'b0, 8'hFF);
    chk("R5 reconnect", port_en[2], 1'b1);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_layout();
    t_isolate_defer();
    t_repeat_connect();
    t_idle_connect();
    t_cancel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule